// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a small on-chip synchronous SRAM that never needs an idle cycle between reads and writes. Each command (address, read/write select, chip enables and lane write selects) is sampled on a rising clock edge. Its data phase comes exactly two cycles later, whether it reads or writes. Because both kinds of access share the same latency, any mix of reads and writes can be issued on consecutive cycles and the data bus stays fully used.

A load/advance control starts a new access or steps an open 4-beat burst. A static order input picks the burst sequence: a linear count-up or an XOR-interleaved sequence. An active-low clock enable freezes the whole pipeline. Three chip enables (two active low, one active high) gate new commands, but accesses already in flight still finish. The bidirectional bus is split into `wrData`, `rdData` and `rdValid`, and an asynchronous output enable can blank the read port at any moment.

Top module: `noturn_sram`

## Requirements
- R1: With `clkEnN` low at an edge and `advLoad` low, a write command (`rdWrN`=0, chip selected) is captured. The word on `wrData` during the cycle between the second and third active edges is stored at the captured address.
- R2: A read command (`rdWrN`=1) captured at an active edge makes `rdValid` high with the stored word on `rdData` after the next active edge. That is the same data cycle that a write issued in the same slot would use.
- R3: Reads and writes may be issued on every cycle in any order. A read issued in the cycle right after a write to the same address returns the newly written lanes.
- R4: While `clkEnN` is high, every input except `outEnN` is ignored and all pipeline, burst and output state holds. Operation resumes where it stopped once `clkEnN` returns low.
- R5: A load cycle (`advLoad`=0) with any chip enable inactive (`chipEn1N`=1, `chipEn2`=0 or `chipEn3N`=1) starts no access, but earlier accesses still complete.
- R6: `rdValid` is low and `rdData` is all zeros in the data cycle of a deselect, a write, or an idle slot, and after reset.
- R7: `outEnN` high forces `rdValid` low and `rdData` to zero at once, without waiting for a clock edge.
- R8: With `interleave`=0, each advance cycle (`advLoad`=1) during an open burst uses the loaded address with its two low bits replaced by (loaded low bits + beat index) mod 4. The beat index is 1, 2, 3, 0, ... so the sequence wraps after the fourth word.
- R9: With `interleave`=1, the low two bits of each burst beat are the loaded low bits XOR the beat index.
- R10: Advance beats keep the read or write type of the load that opened the burst. Each beat takes its lane selects from the advance cycle.
- R11: `laneWrN[i]` low enables a write of bits [9i+8:9i] (8 data bits plus parity). Lanes with `laneWrN[i]` high keep their old contents.
- R12: An advance cycle when no burst is open (after reset or after a deselect) is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| clkEnN | input | 1 | Active-low clock enable; high freezes the block |
| addr | input | 6 | Word address for load cycles |
| rdWrN | input | 1 | 1 = read, 0 = write on load cycles |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| laneWrN | input | 4 | Per-lane write selects, active low |
| advLoad | input | 1 | 0 = load a new command, 1 = advance the open burst |
| interleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| outEnN | input | 1 | Asynchronous active-low output enable |
| wrData | input | 36 | Write data, sampled in the write's data cycle |
| rdData | output | 36 | Read data, zero when not valid |
| rdValid | output | 1 | Read port is driving (models the bus leaving high impedance) |

## Verification
The bench builds the block with the package defaults: 64 words of four 9-bit lanes and a 2-bit beat field. At that depth, every word can be written and read back in one pass. A burst loaded in mid-block reaches both wrap points, where the low bits pass 3 to 0 and the beat index wraps after the fourth word. The narrow lane count makes every partial-write pattern and the same-address write-then-read forwarding easy to reach. Freezes are placed while a write is waiting for its data cycle and while read data is on the port.

// File: rtl/noturn_pkg.sv
package noturn_pkg;
  parameter int ADDR_W = 6;
  parameter int LANES  = 4;
  parameter int LANE_W = 9;
  parameter int BEAT_W = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lanes;
  } cmd_t;

  typedef struct packed {
    logic              step;
    logic              rdLoad;
    logic [ADDR_W-1:0] rdAddr;
    logic              wrCommit;
    logic [ADDR_W-1:0] wrAddr;
    logic [LANES-1:0]  wrLanes;
  } strobe_t;
endpackage

// File: rtl/noturn_ctrl.sv
module noturn_ctrl import noturn_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdWrN,
  input  logic              chipSel,
  input  logic              advLoad,
  input  logic              interleave,
  input  logic [LANES-1:0]  laneWrN,
  output strobe_t           strb
);
  localparam int UP_W = ADDR_W - BEAT_W;

  cmd_t              st1, st2, nextCmd;
  logic              burstOn, burstWr;
  logic [UP_W-1:0]   baseUp;
  logic [BEAT_W-1:0] baseLow, beatIdx, nextIdx, beatLow;

  // Next burst beat: linear adds the index, interleaved XORs it.
  always_comb begin
    nextIdx = beatIdx + BEAT_W'(1);
    beatLow = interleave ? (baseLow ^ nextIdx) : (baseLow + nextIdx);
    nextCmd = '0;
    if (!advLoad) begin
      if (chipSel) begin
        nextCmd.valid = 1'b1;
        nextCmd.write = !rdWrN;
        nextCmd.addr  = addr;
        nextCmd.lanes = ~laneWrN;
      end
    end else if (burstOn) begin
      nextCmd.valid = 1'b1;
      nextCmd.write = burstWr;
      nextCmd.addr  = {baseUp, beatLow};
      nextCmd.lanes = ~laneWrN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st1     <= '0;
      st2     <= '0;
      burstOn <= 1'b0;
      burstWr <= 1'b0;
      baseUp  <= '0;
      baseLow <= '0;
      beatIdx <= '0;
    end else if (!clkEnN) begin
      st1 <= nextCmd;
      st2 <= st1;
      if (!advLoad) begin
        burstOn <= chipSel;
        burstWr <= !rdWrN;
        baseUp  <= addr[ADDR_W-1:BEAT_W];
        baseLow <= addr[BEAT_W-1:0];
        beatIdx <= '0;
      end else if (burstOn) begin
        beatIdx <= nextIdx;
      end
    end
  end

  assign strb.step     = !clkEnN;
  assign strb.rdLoad   = st1.valid && !st1.write;
  assign strb.rdAddr   = st1.addr;
  assign strb.wrCommit = st2.valid && st2.write;
  assign strb.wrAddr   = st2.addr;
  assign strb.wrLanes  = st2.lanes;
endmodule

// File: rtl/noturn_dpath.sv
module noturn_dpath import noturn_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdQ,
  output logic              rdValidQ
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] fetchWord;
  logic              hitWr;

  // A read registered on the same edge as a write commit to its address
  // takes the written lanes straight from the write bus.
  assign hitWr = strb.wrCommit && (strb.wrAddr == strb.rdAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign fetchWord[g*LANE_W +: LANE_W] = (hitWr && strb.wrLanes[g])
                                         ? wrData[g*LANE_W +: LANE_W]
                                         : mem[strb.rdAddr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.step && strb.wrCommit) begin
      for (int i = 0; i < LANES; i++) begin
        if (strb.wrLanes[i]) mem[strb.wrAddr][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ      <= '0;
      rdValidQ <= 1'b0;
    end else if (strb.step) begin
      rdValidQ <= strb.rdLoad;
      if (strb.rdLoad) rdQ <= fetchWord;
    end
  end
endmodule

// File: rtl/noturn_sram.sv
module noturn_sram import noturn_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdWrN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              advLoad,
  input  logic              interleave,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  strobe_t           strb;
  logic [DATA_W-1:0] rdQ;
  logic              rdValidQ;
  logic              chipSel;

  assign chipSel = !chipEn1N && chipEn2 && !chipEn3N;

  noturn_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .addr(addr), .rdWrN(rdWrN),
    .chipSel(chipSel), .advLoad(advLoad), .interleave(interleave),
    .laneWrN(laneWrN), .strb(strb)
  );

  noturn_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdQ(rdQ), .rdValidQ(rdValidQ)
  );

  // Output enable acts without a clock.
  assign rdValid = rdValidQ && !outEnN;
  assign rdData  = rdValid ? rdQ : '0;
endmodule

// File: rtl/noturn_sram_chk.sv
module noturn_sram_chk import noturn_pkg::*; (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              advLoad,
  input logic              chipEn1N,
  input logic              chipEn2,
  input logic              chipEn3N,
  input logic              outEnN,
  input logic              step,
  input logic              rdLoad,
  input logic [DATA_W-1:0] rdQ,
  input logic              rdValidQ,
  input logic              rdValid
);
  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(rdQ) && $stable(rdValidQ)));

  assert_read_out_R2: assert property (@(posedge clk) disable iff (!rstN)
    (step && rdLoad) |=> rdValidQ);

  assert_quiet_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    (step && !rdLoad) |=> !rdValid);

  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLoad && !(!chipEn1N && chipEn2 && !chipEn3N)) |=> !rdLoad);

  assert_out_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !rdValid);
endmodule

bind noturn_sram noturn_sram_chk chk_i (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLoad(advLoad),
  .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N), .outEnN(outEnN),
  .step(strb.step), .rdLoad(strb.rdLoad), .rdQ(rdQ), .rdValidQ(rdValidQ),
  .rdValid(rdValid)
);

// File: tb/noturn_sram_tb_top.sv
module noturn_sram_tb_top;
  import noturn_pkg::*;

  localparam int K_RD = 0, K_WR = 1, K_ADV = 2, K_DES = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN, clkEnN, rdWrN, chipEn1N, chipEn2, chipEn3N;
  logic              advLoad, interleave, outEnN, rdValid;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  laneWrN;
  logic [DATA_W-1:0] wrData, rdData;

  noturn_sram dut_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .addr(addr), .rdWrN(rdWrN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .laneWrN(laneWrN), .advLoad(advLoad), .interleave(interleave),
    .outEnN(outEnN), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  int checks = 0;
  int errors = 0;
  int desCnt = 0;
  bit done = 0;

  // Bench-side expectation, built from the requirements.
  typedef struct {
    bit                v;
    bit                w;
    int                a;
    logic [LANES-1:0]  ln;
    logic [DATA_W-1:0] d;
  } mstage_t;

  mstage_t           m1, m2;
  bit                mOutV;
  logic [DATA_W-1:0] mOut;
  logic [DATA_W-1:0] mMem [DEPTH];
  bit                bOn, bWr;
  int                bBase, bIdx;

  function automatic logic [DATA_W-1:0] pat(int a, int salt);
    return 36'h9_3C5A_1E87 ^ (DATA_W'(a) * 36'h0_0102_0409) ^ (DATA_W'(salt) << 17);
  endfunction

  task automatic chk(string req, logic [DATA_W:0] act, logic [DATA_W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive write data for the pending data cycle, clock once, update the model, compare.
  task automatic tick(string req, mstage_t nc, bit doStep);
    bit eV;
    wrData = (doStep && m2.v && m2.w) ? m2.d : 36'hA_5A5A_5A5A;
    @(posedge clk);
    if (doStep) begin
      if (m2.v && m2.w)
        for (int i = 0; i < LANES; i++)
          if (m2.ln[i]) mMem[m2.a][i*LANE_W +: LANE_W] = wrData[i*LANE_W +: LANE_W];
      if (m1.v && !m1.w) begin
        mOutV = 1'b1;
        mOut  = mMem[m1.a];
      end else begin
        mOutV = 1'b0;
      end
      m2 = m1;
      m1 = nc;
    end
    @(negedge clk);
    eV = mOutV && !outEnN;
    chk(req, {rdValid, rdData}, {eV, eV ? mOut : {DATA_W{1'b0}}});
  endtask

  task automatic op(int kind, int a, logic [DATA_W-1:0] d, logic [LANES-1:0] lanesN, string req);
    mstage_t nc;
    int low;
    nc = '{default: 0};
    clkEnN = 1'b0; addr = a[ADDR_W-1:0]; laneWrN = lanesN;
    chipEn1N = 1'b0; chipEn2 = 1'b1; chipEn3N = 1'b0; advLoad = 1'b0;
    rdWrN = (kind != K_WR);
    if (kind == K_ADV) begin
      advLoad = 1'b1;
      rdWrN = a[0];
      if (bOn) begin
        bIdx = (bIdx + 1) % 4;
        low  = interleave ? ((bBase & 3) ^ bIdx) : (((bBase & 3) + bIdx) % 4);
        nc.v = 1; nc.w = bWr; nc.a = (bBase & ~3) | low;
      end
    end else if (kind == K_DES) begin
      case (desCnt % 3)
        0: chipEn1N = 1'b1;
        1: chipEn2  = 1'b0;
        default: chipEn3N = 1'b1;
      endcase
      desCnt++;
      bOn = 0;
    end else begin
      bOn = 1; bWr = (kind == K_WR); bBase = a; bIdx = 0;
      nc.v = 1; nc.w = bWr; nc.a = a;
    end
    nc.ln = ~lanesN;
    nc.d  = d;
    tick(req, nc, 1'b1);
  endtask

  task automatic hold(string req);
    mstage_t nc;
    nc = '{default: 0};
    clkEnN = 1'b1; addr = ~addr; rdWrN = ~rdWrN; advLoad = ~advLoad;
    chipEn1N = 1'b0; chipEn2 = 1'b1; chipEn3N = 1'b0; laneWrN = '0;
    tick(req, nc, 1'b0);
  endtask

  task automatic flush(string req);
    op(K_DES, 0, '0, '1, req);
    op(K_DES, 0, '0, '1, req);
  endtask

  task automatic test_reset();
    chk("R6 reset", {rdValid, rdData}, '0);
  endtask

  task automatic test_fill();
    interleave = 1'b0;
    for (int a = 0; a < DEPTH; a++) op(K_WR, a, pat(a, 0), '0, "R1 fill write");
    flush("R5 drain after fill");
  endtask

  task automatic test_readback();
    for (int a = 0; a < DEPTH; a++) op(K_RD, a, '0, '1, "R2 read back");
    flush("R6 drain after reads");
  endtask

  task automatic test_mixed();
    for (int i = 0; i < 8; i++) begin
      op(K_WR, 10 + i, pat(i, 7), '0, "R3 write then read");
      op(K_RD, 10 + i, '0, '1, "R3 write then read");
    end
    op(K_RD, 30, '0, '1, "R3 old value");
    op(K_WR, 30, pat(30, 3), '0, "R3 overwrite");
    op(K_RD, 30, '0, '1, "R3 new value");
    op(K_RD, 31, '0, '1, "R3 neighbour");
    flush("R3 drain");
  endtask

  task automatic test_lanes();
    op(K_WR, 5, pat(5, 9), 4'b1010, "R11 lanes 0 and 2");
    op(K_WR, 6, pat(6, 9), 4'b0111, "R11 lane 3 only");
    op(K_RD, 5, '0, '1, "R11 read merged");
    op(K_RD, 6, '0, '1, "R11 read merged");
    flush("R11 drain");
  endtask

  task automatic test_freeze();
    op(K_WR, 7, pat(7, 5), '0, "R4 write before freeze");
    hold("R4 frozen with write pending");
    hold("R4 frozen with write pending");
    op(K_RD, 7, '0, '1, "R4 resume");
    hold("R4 frozen read in flight");
    op(K_RD, 8, '0, '1, "R4 resume read");
    hold("R4 frozen with data on port");
    hold("R4 frozen with data on port");
    flush("R4 drain");
  endtask

  task automatic test_deselect();
    op(K_RD, 1, '0, '1, "R5 read before deselect");
    op(K_WR, 2, pat(2, 4), '0, "R5 write before deselect");
    op(K_DES, 0, '0, '1, "R5 in-flight read completes");
    op(K_DES, 0, '0, '1, "R6 write slot quiet");
    op(K_DES, 0, '0, '1, "R6 deselect slot quiet");
    op(K_RD, 2, '0, '1, "R5 write landed");
    flush("R5 drain");
  endtask

  task automatic test_burst_linear();
    interleave = 1'b0;
    op(K_WR, 22, pat(0, 11), '0, "R10 burst write load");
    for (int k = 1; k < 6; k++) op(K_ADV, 0, pat(k, 11), '0, "R8 linear write beat");
    flush("R8 drain");
    for (int a = 20; a < 24; a++) op(K_RD, a, '0, '1, "R8 linear wrap result");
    op(K_RD, 21, '0, '1, "R10 read burst load");
    for (int k = 1; k < 5; k++) op(K_ADV, 1, '0, '0, "R10 read beat keeps type");
    flush("R10 drain");
  endtask

  task automatic test_burst_interleaved();
    interleave = 1'b1;
    op(K_RD, 41, '0, '1, "R9 interleaved read load");
    for (int k = 1; k < 4; k++) op(K_ADV, 0, '0, '1, "R9 interleaved read beat");
    op(K_WR, 35, pat(35, 2), '0, "R9 interleaved write load");
    for (int k = 1; k < 4; k++) op(K_ADV, 0, pat(k, 2), 4'b1100, "R9 interleaved write beat");
    op(K_RD, 34, '0, '1, "R9 read back load");
    for (int k = 1; k < 4; k++) op(K_ADV, 0, '0, '1, "R9 read back beat");
    flush("R9 drain");
    interleave = 1'b0;
  endtask

  task automatic test_adv_idle();
    op(K_DES, 0, '0, '1, "R12 close burst");
    op(K_ADV, 0, pat(1, 13), '0, "R12 idle advance");
    op(K_ADV, 0, pat(2, 13), '0, "R12 idle advance");
    op(K_ADV, 0, pat(3, 13), '0, "R12 idle advance quiet");
    op(K_ADV, 0, '0, '1, "R12 idle advance quiet");
    for (int a = 32; a < 36; a++) op(K_RD, a, '0, '1, "R12 memory unchanged");
    flush("R12 drain");
  endtask

  task automatic test_out_enable();
    op(K_RD, 2, '0, '1, "R7 read issue");
    op(K_RD, 3, '0, '1, "R7 read on port");
    #1 outEnN = 1'b1;
    #1 chk("R7 forced off", {rdValid, rdData}, '0);
    outEnN = 1'b0;
    #1 chk("R7 released", {rdValid, rdData}, {1'b1, mOut});
    op(K_DES, 0, '0, '1, "R7 second read");
    outEnN = 1'b1;
    op(K_DES, 0, '0, '1, "R7 off across edge");
    outEnN = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clkEnN = 1'b0; addr = '0; rdWrN = 1'b1;
    chipEn1N = 1'b1; chipEn2 = 1'b0; chipEn3N = 1'b1; laneWrN = '1;
    advLoad = 1'b0; interleave = 1'b0; outEnN = 1'b0; wrData = '0;
    m1 = '{default: 0}; m2 = '{default: 0}; mOutV = 0; mOut = '0;
    bOn = 0; bWr = 0; bBase = 0; bIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_adv_idle_reset();
    test_fill();
    test_readback();
    test_mixed();
    test_lanes();
    test_freeze();
    test_deselect();
    test_burst_linear();
    test_burst_interleaved();
    test_adv_idle();
    test_out_enable();
    done = 1;
    summary();
    $finish;
  end

  task automatic test_adv_idle_reset();
    op(K_ADV, 0, '0, '1, "R12 advance after reset");
    op(K_ADV, 0, '0, '1, "R12 advance after reset");
    op(K_ADV, 0, '0, '1, "R12 advance after reset quiet");
  endtask
endmodule